// File: doc/BRIEF.md
# Calendar Shadow Register Synchronizer

This block carries the running time and date of a slow real-time clock domain into a pair of shadow registers that the fast bus domain can read. At a fixed pace set by the slow clock, the current calendar values are captured in the slow domain. The capture is announced to the bus domain by flipping a single toggle bit. After the toggle has passed a multi-flop synchronizer, the bus domain loads both shadows from the captured values and raises a sync-done flag.

Software reads the time shadow first and the date shadow second. A time read locks the pair, so the date that software reads next belongs to the same capture as the time it has just read. While the lock is held, captures are dropped and neither shadow changes. Software may clear the sync-done flag and poll for it to set again, which tells it that fresh data has arrived.

The system reset clears the shadows, the lock and the flag. The slow-domain pacer runs on a separate backup reset, so its capture rhythm survives a system reset. The bus clock must be at least as fast as the slow clock. The shadows are only dependable for single reads when the bus clock is at least seven times faster.

Top module: `cal_shadow_sync`

## Requirements
- R1: While the system reset is asserted, both shadows read zero and sync_done is 0.
- R2: After the system reset is released, sync_done stays 0 and the shadows stay zero until the first copy. That copy loads live values captured at a divider wrap, and it sets sync_done.
- R3: A copy happens once every COPY_DIV (default 2) slow-clock cycles. Each copy loads both shadows bit for bit with one capture. The time layout is hours[23:16], minutes[15:8] and seconds[7:0]. The date layout is year[27:20], month[19:12], day[11:4] and weekday[3:0], all in BCD. With the slow clock at exactly seven bus cycles, successive copies are 14 bus cycles apart.
- R4: sync_done stays 1 until flag_clr is pulsed. A flag_clr pulse in a cycle without a copy makes it 0 from the next cycle on.
- R5: When a copy and flag_clr fall in the same bus cycle, the copy wins and sync_done is 1 afterwards.
- R6: A rd_time pulse takes the lock. From that cycle up to and including the rd_date cycle, no copy happens: both shadows hold their values and sync_done is not set.
- R7: After rd_date releases the lock, the next copy updates both shadows with newer values and sets sync_done.
- R8: The date shadow presented with a rd_date pulse belongs to the same capture as the time shadow presented with the preceding rd_time pulse. This holds even when a copy coincides with either strobe.
- R9: rd_time and rd_date pulsed in the same cycle leave no lock behind, and copies continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow real-time clock |
| rst_bkp_n | input | 1 | Backup-domain reset, active low, for the slow-domain pacer |
| clk_bus | input | 1 | Bus clock |
| rst_sys_n | input | 1 | System reset, active low, for the bus-domain shadows |
| live_time | input | TIME_W | Running time in BCD, slow domain |
| live_date | input | DATE_W | Running date in BCD, slow domain |
| rd_time | input | 1 | One-cycle strobe: the time shadow is being read |
| rd_date | input | 1 | One-cycle strobe: the date shadow is being read |
| flag_clr | input | 1 | One-cycle strobe: clear sync_done |
| shadow_time | output | TIME_W | Time shadow, bus domain |
| shadow_date | output | DATE_W | Date shadow, bus domain |
| sync_done | output | 1 | Set on each copy, cleared by flag_clr |

## Verification
Two collisions matter. A synchronized copy can land in the same bus cycle as a flag clear, and it can land in the same cycle as a read strobe.

The first collision is provoked by holding flag_clr high through many copy periods. The bench then requires sync_done to read 1 in exactly those samples where the shadow value changed, and 0 in every other sample.

The second collision comes from random rd_time and rd_date strobes against a calendar that advances on every slow cycle. Each date read is judged against the date that the bench derives from the time captured at the matching time read.

// File: rtl/cal_shadow_pkg.sv
package cal_shadow_pkg;

   typedef enum logic {
      LK_OPEN = 1'b0,
      LK_HELD = 1'b1
   } lock_e;

   function automatic bit is_bcd_width(int w);
      return (w > 0) && (w % 4 == 0);
   endfunction

endpackage

// File: rtl/cal_copy_pacer.sv
// Slow-domain side: captures live calendar values on a divider wrap
// and flips a toggle that announces the capture to the bus domain.
module cal_copy_pacer #(
   parameter int TIME_W   = 24,
   parameter int DATE_W   = 28,
   parameter int COPY_DIV = 2
) (
   input  logic              clk_slow,
   input  logic              rst_bkp_n,
   input  logic [TIME_W-1:0] live_time,
   input  logic [DATE_W-1:0] live_date,
   output logic              cap_tgl,
   output logic [TIME_W-1:0] hold_time,
   output logic [DATE_W-1:0] hold_date
);

   logic wrap;

   generate
      if (COPY_DIV == 1) begin : g_every
         assign wrap = 1'b1;
      end else begin : g_div
         localparam int CNT_W = $clog2(COPY_DIV);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(COPY_DIV - 1);
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk_slow or negedge rst_bkp_n) begin
            if (!rst_bkp_n)
               cnt <= '0;
            else if (cnt == LAST)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end

         assign wrap = (cnt == LAST);
      end
   endgenerate

   always_ff @(posedge clk_slow or negedge rst_bkp_n) begin
      if (!rst_bkp_n) begin
         cap_tgl   <= 1'b0;
         hold_time <= '0;
         hold_date <= '0;
      end else if (wrap) begin
         cap_tgl   <= ~cap_tgl;
         hold_time <= live_time;
         hold_date <= live_date;
      end
   end

endmodule

// File: rtl/cal_toggle_sync.sv
// Bus-domain side: brings the capture toggle across with STAGES flops
// and turns each toggle edge into a one-cycle event.
module cal_toggle_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tgl_in,
   output logic evt
);

   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chain <= '0;
      else
         chain <= {chain[STAGES-1:0], tgl_in};
   end

   assign evt = chain[STAGES] ^ chain[STAGES-1];

endmodule

// File: rtl/cal_shadow_bank.sv
// Shadow registers, read lock and sync-done flag.
module cal_shadow_bank
   import cal_shadow_pkg::*;
#(
   parameter int TIME_W = 24,
   parameter int DATE_W = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              copy_evt,
   input  logic [TIME_W-1:0] hold_time,
   input  logic [DATE_W-1:0] hold_date,
   input  logic              rd_time,
   input  logic              rd_date,
   input  logic              flag_clr,
   output logic [TIME_W-1:0] shadow_time,
   output logic [DATE_W-1:0] shadow_date,
   output logic              sync_done
);

   lock_e lock_q;
   logic  copy_ok;

   // A copy is dropped while the pair is locked, and also in the very
   // cycle the time is read, so the date that follows stays paired.
   assign copy_ok = copy_evt && (lock_q == LK_OPEN) && !rd_time;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q      <= LK_OPEN;
         shadow_time <= '0;
         shadow_date <= '0;
         sync_done   <= 1'b0;
      end else begin
         if (rd_date)
            lock_q <= LK_OPEN;
         else if (rd_time)
            lock_q <= LK_HELD;

         if (copy_ok) begin
            shadow_time <= hold_time;
            shadow_date <= hold_date;
         end

         if (copy_ok)
            sync_done <= 1'b1;
         else if (flag_clr)
            sync_done <= 1'b0;
      end
   end

endmodule

// File: rtl/cal_shadow_sync.sv
module cal_shadow_sync
   import cal_shadow_pkg::*;
#(
   parameter int TIME_W      = 24,
   parameter int DATE_W      = 28,
   parameter int COPY_DIV    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_slow,
   input  logic              rst_bkp_n,
   input  logic              clk_bus,
   input  logic              rst_sys_n,
   input  logic [TIME_W-1:0] live_time,
   input  logic [DATE_W-1:0] live_date,
   input  logic              rd_time,
   input  logic              rd_date,
   input  logic              flag_clr,
   output logic [TIME_W-1:0] shadow_time,
   output logic [DATE_W-1:0] shadow_date,
   output logic              sync_done
);

   generate
      if (!is_bcd_width(TIME_W)) begin : g_bad_time_w
         $error("TIME_W must be a positive multiple of 4");
      end
      if (!is_bcd_width(DATE_W)) begin : g_bad_date_w
         $error("DATE_W must be a positive multiple of 4");
      end
      if (COPY_DIV < 1) begin : g_bad_div
         $error("COPY_DIV must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              cap_tgl;
   logic              copy_evt;
   logic [TIME_W-1:0] hold_time;
   logic [DATE_W-1:0] hold_date;

   cal_copy_pacer #(
      .TIME_W   (TIME_W),
      .DATE_W   (DATE_W),
      .COPY_DIV (COPY_DIV)
   ) u_pacer (
      .clk_slow  (clk_slow),
      .rst_bkp_n (rst_bkp_n),
      .live_time (live_time),
      .live_date (live_date),
      .cap_tgl   (cap_tgl),
      .hold_time (hold_time),
      .hold_date (hold_date)
   );

   cal_toggle_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk_bus),
      .rst_n  (rst_sys_n),
      .tgl_in (cap_tgl),
      .evt    (copy_evt)
   );

   cal_shadow_bank #(
      .TIME_W (TIME_W),
      .DATE_W (DATE_W)
   ) u_bank (
      .clk         (clk_bus),
      .rst_n       (rst_sys_n),
      .copy_evt    (copy_evt),
      .hold_time   (hold_time),
      .hold_date   (hold_date),
      .rd_time     (rd_time),
      .rd_date     (rd_date),
      .flag_clr    (flag_clr),
      .shadow_time (shadow_time),
      .shadow_date (shadow_date),
      .sync_done   (sync_done)
   );

endmodule

// File: rtl/cal_shadow_sync_chk.sv
module cal_shadow_sync_chk #(
   parameter int TIME_W = 24,
   parameter int DATE_W = 28
) (
   input logic              clk_bus,
   input logic              rst_sys_n,
   input logic              rd_time,
   input logic              rd_date,
   input logic              flag_clr,
   input logic [TIME_W-1:0] shadow_time,
   input logic [DATE_W-1:0] shadow_date,
   input logic              sync_done
);

   // Lock state as software sees it, rebuilt from the strobes alone.
   logic lock_m;

   always_ff @(posedge clk_bus or negedge rst_sys_n) begin
      if (!rst_sys_n)
         lock_m <= 1'b0;
      else if (rd_date)
         lock_m <= 1'b0;
      else if (rd_time)
         lock_m <= 1'b1;
   end

   // R6: no shadow change while locked or in the time-read cycle
   p_frozen_when_locked_r6: assert property (@(posedge clk_bus) disable iff (!rst_sys_n)
      (lock_m || rd_time) |=> ($stable(shadow_time) && $stable(shadow_date)));

   // R6: the flag never rises out of a locked cycle
   p_no_set_when_locked_r6: assert property (@(posedge clk_bus) disable iff (!rst_sys_n)
      $rose(sync_done) |-> (!$past(lock_m) && !$past(rd_time)));

   // R3: every shadow change comes with the flag set
   p_change_sets_flag_r3: assert property (@(posedge clk_bus) disable iff (!rst_sys_n)
      ((shadow_time != $past(shadow_time)) || (shadow_date != $past(shadow_date)))
      |-> sync_done);

   // R4: the flag only falls after a clear strobe
   p_fall_needs_clear_r4: assert property (@(posedge clk_bus) disable iff (!rst_sys_n)
      $fell(sync_done) |-> $past(flag_clr));

   // R4: the flag is sticky without a clear strobe
   p_flag_sticky_r4: assert property (@(posedge clk_bus) disable iff (!rst_sys_n)
      (sync_done && !flag_clr) |=> sync_done);

endmodule

bind cal_shadow_sync cal_shadow_sync_chk #(
   .TIME_W (TIME_W),
   .DATE_W (DATE_W)
) u_chk (
   .clk_bus     (clk_bus),
   .rst_sys_n   (rst_sys_n),
   .rd_time     (rd_time),
   .rd_date     (rd_date),
   .flag_clr    (flag_clr),
   .shadow_time (shadow_time),
   .shadow_date (shadow_date),
   .sync_done   (sync_done)
);

// File: tb/sim_cal_shadow_sync.sv
module sim_cal_shadow_sync;

   localparam int TW = 24;
   localparam int DW = 28;
   localparam int COPY_GAP = 14;  // 2 slow cycles of 7 bus cycles

   logic clk_bus = 1'b0;
   logic clk_slow = 1'b0;
   logic rst_sys_n = 1'b0;
   logic rst_bkp_n = 1'b0;
   logic rd_time = 1'b0;
   logic rd_date = 1'b0;
   logic flag_clr = 1'b0;
   logic live_run = 1'b0;
   logic [TW-1:0] live_time;
   logic [DW-1:0] live_date;
   logic [TW-1:0] shadow_time;
   logic [DW-1:0] shadow_date;
   logic sync_done;

   int k = 100;
   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;

   always #10 clk_bus = ~clk_bus;
   initial begin
      #3;
      forever #70 clk_slow = ~clk_slow;
   end

   always @(posedge clk_bus) cyc <= cyc + 1;
   always @(negedge clk_slow) if (live_run) k <= k + 1;

   function automatic logic [7:0] bcd8(int n);
      return {4'(n / 10), 4'(n % 10)};
   endfunction

   function automatic logic [TW-1:0] t_of(int n);
      return {bcd8((n / 3600) % 24), bcd8((n / 60) % 60), bcd8(n % 60)};
   endfunction

   function automatic logic [DW-1:0] d_of(int n);
      return {bcd8((n / 336) % 100), bcd8((n / 28) % 12 + 1), bcd8(n % 28 + 1), 4'(n % 7 + 1)};
   endfunction

   function automatic int k_of_t(logic [TW-1:0] t);
      int h, m, s;
      h = int'(t[23:20]) * 10 + int'(t[19:16]);
      m = int'(t[15:12]) * 10 + int'(t[11:8]);
      s = int'(t[7:4]) * 10 + int'(t[3:0]);
      return h * 3600 + m * 60 + s;
   endfunction

   assign live_time = t_of(k);
   assign live_date = d_of(k);

   cal_shadow_sync u0 (
      .clk_slow    (clk_slow),
      .rst_bkp_n   (rst_bkp_n),
      .clk_bus     (clk_bus),
      .rst_sys_n   (rst_sys_n),
      .live_time   (live_time),
      .live_date   (live_date),
      .rd_time     (rd_time),
      .rd_date     (rd_date),
      .flag_clr    (flag_clr),
      .shadow_time (shadow_time),
      .shadow_date (shadow_date),
      .sync_done   (sync_done)
   );

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk_bus);
   endtask

   task automatic wait_flag(int limit);
      int n = 0;
      while (!sync_done && n < limit) begin
         tick();
         n++;
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk_bus);
      n_bad++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      int prev_cyc, prev_k, kt, nchg, kp, bad0;
      bit pend;
      logic [TW-1:0] t_lk, prev_t;
      logic [DW-1:0] d_lk;
      void'($urandom(32'd4711));

      // R1: reset state
      repeat (5) tick();
      chk(shadow_time == '0, "R1", "time in reset", shadow_time, 0);
      chk(shadow_date == '0, "R1", "date in reset", shadow_date, 0);
      chk(sync_done == 1'b0, "R1", "flag in reset", sync_done, 0);
      rst_bkp_n = 1'b1;
      rst_sys_n = 1'b1;

      // R2: nothing before the first copy, then the held live value
      bad0 = 0;
      for (int i = 0; i < 80 && !sync_done; i++) begin
         if (shadow_time != '0 || shadow_date != '0) bad0++;
         tick();
      end
      chk(bad0 == 0, "R2", "shadow nonzero before first copy", bad0, 0);
      chk(sync_done == 1'b1, "R2", "first copy flag", sync_done, 1);
      chk(shadow_time == t_of(100), "R2", "first time", shadow_time, t_of(100));
      chk(shadow_date == d_of(100), "R2", "first date", shadow_date, d_of(100));

      // R3 / R4: copy pacing with a running calendar
      live_run = 1'b1;
      flag_clr = 1'b1; tick(); flag_clr = 1'b0;
      prev_cyc = 0; prev_k = 0;
      for (int n = 0; n < 8; n++) begin
         wait_flag(60);
         chk(sync_done == 1'b1, "R3", "copy seen", sync_done, 1);
         kt = k_of_t(shadow_time);
         chk(shadow_date == d_of(kt), "R3", "pair from one capture", shadow_date, d_of(kt));
         if (n > 0) begin
            chk(cyc - prev_cyc == COPY_GAP, "R3", "copy spacing", cyc - prev_cyc, COPY_GAP);
            chk(kt - prev_k == 2, "R3", "calendar step per copy", kt - prev_k, 2);
         end
         prev_cyc = cyc; prev_k = kt;
         flag_clr = 1'b1; tick(); flag_clr = 1'b0;
         chk(sync_done == 1'b0, "R4", "flag after clear", sync_done, 0);
      end

      // R4: sticky without clear
      wait_flag(60);
      repeat (3) tick();
      chk(sync_done == 1'b1, "R4", "flag sticky", sync_done, 1);

      // R6 / R7 / R8: lock by time read
      flag_clr = 1'b1; tick(); flag_clr = 1'b0;
      t_lk = shadow_time; d_lk = shadow_date;
      rd_time = 1'b1; tick(); rd_time = 1'b0;
      bad0 = 0;
      for (int i = 0; i < 50; i++) begin
         if (shadow_time != t_lk || shadow_date != d_lk || sync_done) bad0++;
         tick();
      end
      chk(bad0 == 0, "R6", "samples changed while locked", bad0, 0);
      chk(shadow_date == d_of(k_of_t(t_lk)), "R8", "locked date pairs time", shadow_date, d_of(k_of_t(t_lk)));
      rd_date = 1'b1; tick(); rd_date = 1'b0;
      wait_flag(60);
      chk(sync_done == 1'b1, "R7", "copy after unlock", sync_done, 1);
      chk(k_of_t(shadow_time) > k_of_t(t_lk), "R7", "newer time", k_of_t(shadow_time), k_of_t(t_lk) + 1);
      chk(shadow_date == d_of(k_of_t(shadow_time)), "R7", "date after unlock", shadow_date, d_of(k_of_t(shadow_time)));

      // R5: clear held high across copies
      flag_clr = 1'b1;
      tick();
      prev_t = shadow_time; nchg = 0;
      for (int i = 0; i < 100; i++) begin
         tick();
         if (shadow_time != prev_t) begin
            nchg++;
            chk(sync_done == 1'b1, "R5", "copy beats clear", sync_done, 1);
         end else begin
            chk(sync_done == 1'b0, "R5", "clear without copy", sync_done, 0);
         end
         prev_t = shadow_time;
      end
      flag_clr = 1'b0;
      chk(nchg >= 5, "R5", "copies during clear", nchg, 5);

      // R9: both strobes together leave no lock
      rd_time = 1'b1; rd_date = 1'b1; tick(); rd_time = 1'b0; rd_date = 1'b0;
      wait_flag(60);
      chk(sync_done == 1'b1, "R9", "copies continue", sync_done, 1);

      // R8: random read strobes against copies
      pend = 1'b0; kp = 0;
      for (int i = 0; i < 3000; i++) begin
         bit rt, rdd;
         rt  = ($urandom % 8) == 0;
         rdd = ($urandom % 8) == 0;
         flag_clr = ($urandom % 6) == 0;
         if (rdd) begin
            if (rt)
               chk(shadow_date == d_of(k_of_t(shadow_time)), "R8", "same-cycle pair", shadow_date, d_of(k_of_t(shadow_time)));
            else if (pend)
               chk(shadow_date == d_of(kp), "R8", "date matches read time", shadow_date, d_of(kp));
            pend = 1'b0;
         end else if (rt) begin
            kp = k_of_t(shadow_time);
            pend = 1'b1;
         end
         rd_time = rt; rd_date = rdd;
         tick();
      end
      rd_time = 1'b0; rd_date = 1'b0; flag_clr = 1'b0;
      tick();

      // R1 / R2: system reset alone, pacer keeps running
      rst_sys_n = 1'b0;
      repeat (3) tick();
      chk(shadow_time == '0 && shadow_date == '0, "R1", "shadows in system reset", shadow_time, 0);
      chk(sync_done == 1'b0, "R1", "flag in system reset", sync_done, 0);
      rst_sys_n = 1'b1;
      wait_flag(60);
      chk(sync_done == 1'b1, "R2", "copy after system reset", sync_done, 1);
      kt = k_of_t(shadow_time);
      chk(shadow_date == d_of(kt), "R2", "pair after system reset", shadow_date, d_of(kt));
      chk(kt <= k && kt >= k - 4, "R2", "recent capture", kt, k);

      summary();
      $finish;
   end

endmodule